// File: doc/BRIEF.md
# Audio Channel Count Converter

This block adapts the number of channels in an audio frame on its way between a sample buffer and a serial audio port. It has two independent datapaths. The downmix path takes a two-channel frame and produces one sample: channel 0, channel 1, or the average of the two, as chosen by its own mode input. The upmix path takes one sample and produces a two-sample frame: either the sample followed by a zero, or the sample on both channels, as chosen by a separate mode input.

Every sample is signed, 8, 16 or 32 bits wide, carried in the low bits of a 32-bit bus and returned sign-extended to 32 bits. Both sides of both paths use valid/ready handshakes.

A third section watches the buffer fill level, counted in frames. The requested threshold is clamped to the largest value the buffer can hold for the current channel count. A flag reports when the stored frame count has reached the clamped threshold.

Top module: `chan_count_conv`

## Requirements
- R1: Downmix mode code 0 outputs channel 0 and code 1 outputs channel 1. Code 3 behaves like code 0.
- R2: Downmix mode code 2 outputs floor((ch0 + ch1) / 2), computed on the sign-extended samples without overflow.
- R3: Width code 0 selects 8-bit samples, code 1 selects 16-bit samples, and codes 2 and 3 select 32-bit samples. Input bits above the selected width are ignored. Every output is sign-extended from the selected width.
- R4: Upmix mode 0 emits the sample and then zero. Upmix mode 1 emits the sample twice. `up_out_last` is 1 on the second sample and 0 on the first.
- R5: `up_in_ready` is low whenever an upmix output sample is pending, including while the second sample is presented. The path therefore accepts one input per three cycles when the output is always ready.
- R6: An output held with valid high and ready low keeps its valid and its data unchanged. A new input is not accepted while the output is stalled.
- R7: A downmix frame accepted at a clock edge is presented on the output from that edge. `dn_in_ready` equals `!dn_out_valid || dn_out_ready`, so the path accepts one frame per cycle when the output is always ready.
- R8: One cycle after its inputs, `thr_eff` equals min(`thr_req`, DEPTH/ch - 1). Here ch is `thr_chans`, with 0 read as 1 and values above MAX_CH read as MAX_CH.
- R9: One cycle after its inputs, `thr_reached` is 1 exactly when `fifo_fill` is at least the clamped threshold computed from those same inputs.
- R10: During reset both output valids, `thr_eff` and `thr_reached` are 0.
- R11: The mode settings of the two paths are independent. Changing the downmix mode does not alter upmix output, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_sel | input | 2 | Sample width code (R3) |
| dn_mode | input | 2 | Downmix mode code |
| dn_in_valid | input | 1 | Downmix frame valid |
| dn_in_ready | output | 1 | Downmix frame accepted |
| dn_in_ch0 | input | 32 | Downmix channel 0 sample |
| dn_in_ch1 | input | 32 | Downmix channel 1 sample |
| dn_out_valid | output | 1 | Downmix sample valid |
| dn_out_ready | input | 1 | Downmix sample taken |
| dn_out_data | output | 32 | Downmix sample, sign-extended |
| up_mode | input | 1 | Upmix mode: 0 zero-fill, 1 duplicate |
| up_in_valid | input | 1 | Upmix sample valid |
| up_in_ready | output | 1 | Upmix sample accepted |
| up_in_data | input | 32 | Upmix input sample |
| up_out_valid | output | 1 | Upmix sample valid |
| up_out_ready | input | 1 | Upmix sample taken |
| up_out_data | output | 32 | Upmix sample, sign-extended |
| up_out_last | output | 1 | Second sample of the frame |
| thr_req | input | 6 | Requested threshold in frames |
| thr_chans | input | 5 | Channel count for the clamp |
| fifo_fill | input | 7 | Stored frame count |
| thr_eff | output | 6 | Clamped threshold |
| thr_reached | output | 1 | Fill level at or above threshold |

## Verification
The assertions check on every cycle that stalled outputs hold steady on both paths and that upmix input is refused while a sample is pending. They also check that the downmix path refuses input under backpressure, that a first upmix sample is always followed by a second, and that the clamped threshold never exceeds the request or the limit for the largest channel count. The arithmetic cannot be proven by those properties and is left to the bench scenarios. That covers channel selection, floor averaging of mixed-sign and extreme values, sign extension at each width, zero-fill versus duplication, the exact clamp limits, and the threshold flag at its boundary.

// File: rtl/chconv_pkg.sv
package chconv_pkg;

    localparam int SMP_W = 32;

    typedef logic [SMP_W-1:0] smp_t;

    typedef enum logic [1:0] {
        DN_CH0 = 2'd0,
        DN_CH1 = 2'd1,
        DN_AVG = 2'd2,
        DN_RSV = 2'd3
    } dn_mode_e;

    typedef enum logic {
        UP_ZERO = 1'b0,
        UP_DUP  = 1'b1
    } up_mode_e;

    // Sign-extend the low bits of a sample per width code (0:8, 1:16, else 32)
    function automatic smp_t sext_w(input smp_t x, input logic [1:0] wsel);
        smp_t r;
        case (wsel)
            2'd0:    r = {{(SMP_W-8){x[7]}}, x[7:0]};
            2'd1:    r = {{(SMP_W-16){x[15]}}, x[15:0]};
            default: r = x;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chconv_downmix.sv
module chconv_downmix
    import chconv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] width_sel,
    input  logic [1:0] mode,
    input  logic       in_valid,
    output logic       in_ready,
    input  smp_t       in_ch0,
    input  smp_t       in_ch1,
    output logic       out_valid,
    input  logic       out_ready,
    output smp_t       out_data
);

    typedef struct packed {
        logic vld;
        smp_t data;
    } dn_state_t;

    dn_state_t st_d, st_q;

    smp_t           a_ext, b_ext, pick;
    logic [SMP_W:0] sum;

    always_comb begin
        a_ext = sext_w(in_ch0, width_sel);
        b_ext = sext_w(in_ch1, width_sel);
        sum   = {a_ext[SMP_W-1], a_ext} + {b_ext[SMP_W-1], b_ext};
        case (dn_mode_e'(mode))
            DN_CH1:  pick = b_ext;
            DN_AVG:  pick = sum[SMP_W:1];
            default: pick = a_ext;
        endcase

        st_d     = st_q;
        in_ready = !st_q.vld || out_ready;
        if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
        if (in_valid && in_ready) begin
            st_d.vld  = 1'b1;
            st_d.data = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

endmodule

// File: rtl/chconv_upmix.sv
module chconv_upmix
    import chconv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] width_sel,
    input  logic       mode,
    input  logic       in_valid,
    output logic       in_ready,
    input  smp_t       in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output smp_t       out_data,
    output logic       out_last
);

    typedef struct packed {
        logic vld;
        logic second;
        smp_t data;
        smp_t hold;
    } up_state_t;

    up_state_t st_d, st_q;
    smp_t      s_ext;

    always_comb begin
        s_ext    = sext_w(in_data, width_sel);
        st_d     = st_q;
        in_ready = !st_q.vld;
        if (st_q.vld && out_ready) begin
            if (!st_q.second) begin
                st_d.second = 1'b1;
                st_d.data   = st_q.hold;
            end else begin
                st_d.vld    = 1'b0;
                st_d.second = 1'b0;
            end
        end
        if (in_valid && in_ready) begin
            st_d.vld    = 1'b1;
            st_d.second = 1'b0;
            st_d.data   = s_ext;
            st_d.hold   = (up_mode_e'(mode) == UP_DUP) ? s_ext : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_last  = st_q.second;

endmodule

// File: rtl/chconv_thresh.sv
module chconv_thresh #(
    parameter int DEPTH  = 64,
    parameter int MAX_CH = 16,
    localparam int TH_W   = $clog2(DEPTH),
    localparam int FILL_W = $clog2(DEPTH + 1),
    localparam int CH_W   = $clog2(MAX_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TH_W-1:0]   req,
    input  logic [CH_W-1:0]   chans,
    input  logic [FILL_W-1:0] fill,
    output logic [TH_W-1:0]   eff,
    output logic              reached
);

    typedef struct packed {
        logic [TH_W-1:0] eff;
        logic            reached;
    } th_state_t;

    th_state_t st_d, st_q;

    // Per-channel-count frame limit, computed at elaboration
    logic [TH_W-1:0] lim_tab [MAX_CH+1];

    assign lim_tab[0] = TH_W'(DEPTH - 1);
    for (genvar k = 1; k <= MAX_CH; k++) begin : g_lim
        assign lim_tab[k] = TH_W'(DEPTH / k - 1);
    end

    logic [CH_W-1:0] ch_c;
    logic [TH_W-1:0] lim;

    always_comb begin
        if (chans == '0) begin
            ch_c = CH_W'(1);
        end else if (chans > CH_W'(MAX_CH)) begin
            ch_c = CH_W'(MAX_CH);
        end else begin
            ch_c = chans;
        end
        lim          = lim_tab[ch_c];
        st_d.eff     = (req > lim) ? lim : req;
        st_d.reached = (fill >= FILL_W'(st_d.eff));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eff     = st_q.eff;
    assign reached = st_q.reached;

endmodule

// File: rtl/chan_count_conv.sv
module chan_count_conv
    import chconv_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int MAX_CH = 16,
    localparam int TH_W   = $clog2(DEPTH),
    localparam int FILL_W = $clog2(DEPTH + 1),
    localparam int CH_W   = $clog2(MAX_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        width_sel,
    input  logic [1:0]        dn_mode,
    input  logic              dn_in_valid,
    output logic              dn_in_ready,
    input  logic [31:0]       dn_in_ch0,
    input  logic [31:0]       dn_in_ch1,
    output logic              dn_out_valid,
    input  logic              dn_out_ready,
    output logic [31:0]       dn_out_data,
    input  logic              up_mode,
    input  logic              up_in_valid,
    output logic              up_in_ready,
    input  logic [31:0]       up_in_data,
    output logic              up_out_valid,
    input  logic              up_out_ready,
    output logic [31:0]       up_out_data,
    output logic              up_out_last,
    input  logic [TH_W-1:0]   thr_req,
    input  logic [CH_W-1:0]   thr_chans,
    input  logic [FILL_W-1:0] fifo_fill,
    output logic [TH_W-1:0]   thr_eff,
    output logic              thr_reached
);

    chconv_downmix i_dn (
        .clk       (clk),
        .rst_n     (rst_n),
        .width_sel (width_sel),
        .mode      (dn_mode),
        .in_valid  (dn_in_valid),
        .in_ready  (dn_in_ready),
        .in_ch0    (dn_in_ch0),
        .in_ch1    (dn_in_ch1),
        .out_valid (dn_out_valid),
        .out_ready (dn_out_ready),
        .out_data  (dn_out_data)
    );

    chconv_upmix i_up (
        .clk       (clk),
        .rst_n     (rst_n),
        .width_sel (width_sel),
        .mode      (up_mode),
        .in_valid  (up_in_valid),
        .in_ready  (up_in_ready),
        .in_data   (up_in_data),
        .out_valid (up_out_valid),
        .out_ready (up_out_ready),
        .out_data  (up_out_data),
        .out_last  (up_out_last)
    );

    chconv_thresh #(
        .DEPTH  (DEPTH),
        .MAX_CH (MAX_CH)
    ) i_th (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (thr_req),
        .chans   (thr_chans),
        .fill    (fifo_fill),
        .eff     (thr_eff),
        .reached (thr_reached)
    );

endmodule

// File: rtl/chconv_checker.sv
module chconv_checker #(
    parameter int DEPTH  = 64,
    parameter int MAX_CH = 16,
    localparam int TH_W  = $clog2(DEPTH),
    localparam int CH_W  = $clog2(MAX_CH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dn_in_ready,
    input logic            dn_out_valid,
    input logic            dn_out_ready,
    input logic [31:0]     dn_out_data,
    input logic            up_in_ready,
    input logic            up_out_valid,
    input logic            up_out_ready,
    input logic [31:0]     up_out_data,
    input logic            up_out_last,
    input logic [TH_W-1:0] thr_req,
    input logic [CH_W-1:0] thr_chans,
    input logic [TH_W-1:0] thr_eff
);

    AST_DN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        dn_out_valid && !dn_out_ready |=> dn_out_valid && $stable(dn_out_data)); // R6

    AST_DN_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_out_valid && !dn_out_ready |-> !dn_in_ready); // R7

    AST_UP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        up_out_valid && !up_out_ready |=> up_out_valid && $stable(up_out_data) && $stable(up_out_last)); // R6

    AST_UP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        up_out_valid |-> !up_in_ready); // R5

    AST_UP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        up_out_valid && up_out_ready && !up_out_last |=> up_out_valid && up_out_last); // R4

    AST_THR_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> thr_eff <= $past(thr_req)); // R8

    AST_THR_MAXCH: assert property (@(posedge clk) disable iff (!rst_n)
        thr_chans >= CH_W'(MAX_CH) |=> thr_eff <= TH_W'(DEPTH / MAX_CH - 1)); // R8

endmodule

bind chan_count_conv chconv_checker #(
    .DEPTH  (DEPTH),
    .MAX_CH (MAX_CH)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dn_in_ready  (dn_in_ready),
    .dn_out_valid (dn_out_valid),
    .dn_out_ready (dn_out_ready),
    .dn_out_data  (dn_out_data),
    .up_in_ready  (up_in_ready),
    .up_out_valid (up_out_valid),
    .up_out_ready (up_out_ready),
    .up_out_data  (up_out_data),
    .up_out_last  (up_out_last),
    .thr_req      (thr_req),
    .thr_chans    (thr_chans),
    .thr_eff      (thr_eff)
);

// File: tb/test_chan_count_conv.sv
module test_chan_count_conv;

    localparam int DEPTH  = 64;
    localparam int MAX_CH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  width_sel = 2'd2;
    logic [1:0]  dn_mode = 2'd0;
    logic        dn_in_valid = 1'b0;
    logic        dn_in_ready;
    logic [31:0] dn_in_ch0 = '0;
    logic [31:0] dn_in_ch1 = '0;
    logic        dn_out_valid;
    logic        dn_out_ready = 1'b1;
    logic [31:0] dn_out_data;
    logic        up_mode = 1'b0;
    logic        up_in_valid = 1'b0;
    logic        up_in_ready;
    logic [31:0] up_in_data = '0;
    logic        up_out_valid;
    logic        up_out_ready = 1'b1;
    logic [31:0] up_out_data;
    logic        up_out_last;
    logic [5:0]  thr_req = '0;
    logic [4:0]  thr_chans = 5'd2;
    logic [6:0]  fifo_fill = '0;
    logic [5:0]  thr_eff;
    logic        thr_reached;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    chan_count_conv #(.DEPTH(DEPTH), .MAX_CH(MAX_CH)) i_chan_count_conv (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_sext(input logic [31:0] x, input logic [1:0] w);
        if (w == 2'd0) return {{24{x[7]}}, x[7:0]};
        if (w == 2'd1) return {{16{x[15]}}, x[15:0]};
        return x;
    endfunction

    function automatic logic [31:0] ref_dn(input logic [31:0] a, input logic [31:0] b,
                                           input logic [1:0] m, input logic [1:0] w);
        longint sa, sb, s;
        sa = longint'(signed'(ref_sext(a, w)));
        sb = longint'(signed'(ref_sext(b, w)));
        if (m == 2'd1) return ref_sext(b, w);
        if (m == 2'd2) begin
            s = (sa + sb) >>> 1;
            return s[31:0];
        end
        return ref_sext(a, w);
    endfunction

    function automatic logic [5:0] ref_eff(input int req, input int ch);
        int c, lim;
        c   = (ch == 0) ? 1 : (ch > MAX_CH ? MAX_CH : ch);
        lim = DEPTH / c - 1;
        return 6'(req > lim ? lim : req);
    endfunction

    // one downmix frame, output always ready
    task automatic dn_frame(input string req, input logic [1:0] m, input logic [1:0] w,
                            input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        dn_mode = m; width_sel = w; dn_in_ch0 = a; dn_in_ch1 = b; dn_in_valid = 1'b1;
        @(negedge clk);
        dn_in_valid = 1'b0;
        chk({req, " valid"}, 32'(dn_out_valid), 32'd1);
        chk({req, " data"}, dn_out_data, ref_dn(a, b, m, w));
    endtask

    task automatic t_reset;
        chk("R10 dn_out_valid", 32'(dn_out_valid), 32'd0);
        chk("R10 up_out_valid", 32'(up_out_valid), 32'd0);
        chk("R10 thr_eff", 32'(thr_eff), 32'd0);
        chk("R10 thr_reached", 32'(thr_reached), 32'd0);
    endtask

    task automatic t_select;
        dn_frame("R1 mode0", 2'd0, 2'd2, 32'h1234_5678, 32'h8765_4321);
        dn_frame("R1 mode1", 2'd1, 2'd2, 32'h1234_5678, 32'h8765_4321);
        dn_frame("R1 mode3", 2'd3, 2'd2, 32'hCAFE_0001, 32'h0000_0002);
    endtask

    task automatic t_average;
        dn_frame("R2 pos", 2'd2, 2'd2, 32'd10, 32'd5);
        dn_frame("R2 neg floor", 2'd2, 2'd2, 32'hFFFF_FFFF, 32'd0);
        dn_frame("R2 max", 2'd2, 2'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        dn_frame("R2 min", 2'd2, 2'd2, 32'h8000_0000, 32'h8000_0000);
        dn_frame("R2 mixed 16", 2'd2, 2'd1, 32'h0000_8000, 32'h0000_7FFF);
    endtask

    task automatic t_width;
        dn_frame("R3 w8 junk", 2'd0, 2'd0, 32'hABCD_EF80, 32'd0);
        dn_frame("R3 w16", 2'd1, 2'd1, 32'd0, 32'h5555_7FFE);
        dn_frame("R3 w3 as 32", 2'd0, 2'd3, 32'h8000_00FF, 32'd0);
        dn_frame("R3 w8 avg", 2'd2, 2'd0, 32'h0000_0080, 32'h0000_0081);
    endtask

    task automatic t_throughput;
        // back-to-back frames, one per cycle (R7)
        @(negedge clk);
        dn_mode = 2'd0; width_sel = 2'd2;
        dn_in_ch0 = 32'd100; dn_in_valid = 1'b1;
        @(negedge clk);
        chk("R7 first", dn_out_data, 32'd100);
        chk("R7 ready", 32'(dn_in_ready), 32'd1);
        dn_in_ch0 = 32'd101;
        @(negedge clk);
        chk("R7 second", dn_out_data, 32'd101);
        dn_in_valid = 1'b0;
        @(negedge clk);
        chk("R7 drained", 32'(dn_out_valid), 32'd0);
    endtask

    task automatic t_dn_stall;
        @(negedge clk);
        dn_out_ready = 1'b0;
        dn_mode = 2'd0; width_sel = 2'd2;
        dn_in_ch0 = 32'h0000_0AAA; dn_in_valid = 1'b1;
        @(negedge clk);
        dn_in_ch0 = 32'h0000_0BBB;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 dn hold", dn_out_data, 32'h0000_0AAA);
            chk("R7 dn refuse", 32'(dn_in_ready), 32'd0);
        end
        dn_out_ready = 1'b1;
        @(negedge clk);
        chk("R6 dn next", dn_out_data, 32'h0000_0BBB);
        dn_in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic up_frame(input string req, input logic m, input logic [1:0] w,
                            input logic [31:0] s);
        logic [31:0] e;
        e = ref_sext(s, w);
        @(negedge clk);
        up_mode = m; width_sel = w; up_in_data = s; up_in_valid = 1'b1;
        @(negedge clk);
        up_in_valid = 1'b0;
        chk({req, " first"}, up_out_data, e);
        chk({req, " first last"}, 32'(up_out_last), 32'd0);
        chk({req, " R5 busy1"}, 32'(up_in_ready), 32'd0);
        // change the other path's mode: must not matter (R11)
        dn_mode = 2'd1;
        @(negedge clk);
        chk({req, " second"}, up_out_data, m ? e : 32'd0);
        chk({req, " second last"}, 32'(up_out_last), 32'd1);
        chk({req, " R5 busy2"}, 32'(up_in_ready), 32'd0);
        @(negedge clk);
        chk({req, " R5 free"}, 32'(up_in_ready), 32'd1);
        chk({req, " done"}, 32'(up_out_valid), 32'd0);
        dn_mode = 2'd0;
    endtask

    task automatic t_upmix;
        up_frame("R4 zero R11", 1'b0, 2'd2, 32'hDEAD_BEEF);
        up_frame("R4 dup R11", 1'b1, 2'd1, 32'h0000_9001);
        up_frame("R4 dup R3 w8", 1'b1, 2'd0, 32'h1111_117F);
    endtask

    task automatic t_up_stall;
        @(negedge clk);
        up_out_ready = 1'b0;
        up_mode = 1'b1; width_sel = 2'd2; up_in_data = 32'h0000_0042; up_in_valid = 1'b1;
        @(negedge clk);
        up_in_valid = 1'b0;
        @(negedge clk);
        chk("R6 up hold", up_out_data, 32'h0000_0042);
        chk("R6 up last", 32'(up_out_last), 32'd0);
        up_out_ready = 1'b1;
        @(negedge clk);
        chk("R4 up second after stall", 32'(up_out_last), 32'd1);
        @(negedge clk);
    endtask

    task automatic t_thresh(input string req, input int r, input int ch, input int f);
        @(negedge clk);
        thr_req = 6'(r); thr_chans = 5'(ch); fifo_fill = 7'(f);
        @(negedge clk);
        chk({req, " eff"}, 32'(thr_eff), 32'(ref_eff(r, ch)));
        chk({req, " reached"}, 32'(thr_reached), 32'(f >= int'(ref_eff(r, ch))));
    endtask

    initial begin
        // checked during reset, before any clock edge matters
        #12;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_select();
        t_average();
        t_width();
        t_throughput();
        t_dn_stall();
        t_upmix();
        t_up_stall();
        t_thresh("R8 ch3 clamp", 40, 3, 20);
        t_thresh("R8 ch2 pass", 10, 2, 9);
        t_thresh("R9 equal", 10, 2, 10);
        t_thresh("R8 ch16", 63, 16, 2);
        t_thresh("R8 ch0 as 1", 63, 0, 63);
        t_thresh("R8 ch20 as max", 30, 20, 3);
        t_thresh("R9 zero thr", 0, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule